// File: doc/BRIEF.md
# JTAG Test Access Port

This block is the test access port of a small processing core. A 16-state controller advances on the rising edge of TCK under TMS and can be forced to its reset state at any time by an active-low TRST. The controller steers a 4-bit instruction register and three data paths between TDI and TDO: a one-bit bypass stage, a 32-bit identification register, and an internal scan chain built from a row of output cells and a row of input cells.

The scan chain captures the values that the core sends towards its outputs and the values that the system sends towards the core's inputs. While the scan instruction is in force, the chain's cells switch to test mode and drive parallel test values in place of those live signals. Under the other instructions every cell passes the live value straight through. TDO is launched on the falling edge of TCK and is enabled only while a shift state is active.

Top module: `tap_port`

## Requirements
- R1: The controller follows the standard 16-state transition graph on rising TCK edges. Five rising edges with TMS high reach Test-Logic-Reset from any state. A low level on trst_n forces Test-Logic-Reset, clears test mode and disables TDO at once, without waiting for a clock edge.
- R2: A rising edge taken in Test-Logic-Reset sets the instruction to IDCODE (4'b1110). After reset test_mode is 0 and tdo_en is 0.
- R3: A rising edge in Capture-IR loads 4'b0001 into the instruction shift stage. Each rising edge in Shift-IR moves TDI into bit 3, and bit 0 is presented on TDO, so the bits appear LSB first. A rising edge in Update-IR makes the shifted value the current instruction.
- R4: Instruction 4'b1111 selects bypass, 4'b1110 selects the identification register, and 4'b1100 selects the scan chain. Every other code selects bypass.
- R5: Under bypass, Capture-DR loads 0. Each Shift-DR edge delays TDI by exactly one bit on its way to TDO.
- R6: Under IDCODE, Capture-DR loads the 32-bit identity {version[31:28], part[27:12], manufacturer[11:1], 1'b1}, which has bit 0 equal to 1. Shift-DR sends the old contents out LSB first and takes TDI in at bit 31. Passing through Pause-DR and Exit2-DR keeps the contents intact.
- R7: Under IDCODE or bypass, Update-DR changes nothing: test_mode stays 0 and core_drv and pin_drv keep following sys_val and core_val.
- R8: test_mode is 1 exactly while the current instruction is 4'b1100. In Capture-DR under that instruction, chain bits [SYS_W-1:0] (nearest TDO) load sys_val and the upper CORE_W bits load core_val. The chain then shifts LSB first.
- R9: Under 4'b1100, Update-DR copies the chain into the parallel stage. While test_mode is 1, core_drv shows stage bits [SYS_W-1:0] and pin_drv shows the upper bits. While test_mode is 0, core_drv equals sys_val and pin_drv equals core_val.
- R10: TDO and tdo_en change only on falling TCK edges. tdo_en is 1 only in the low phase after an edge that entered or stayed in Shift-IR or Shift-DR. TDO is 0 whenever tdo_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| core_val | input | CORE_W | Values the core drives towards the output cells |
| sys_val | input | SYS_W | Values the system drives towards the input cells |
| tdo | output | 1 | Serial data out, launched on falling tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| test_mode | output | 1 | High while the scan cells are in test mode |
| core_drv | output | SYS_W | Values presented to the core's inputs |
| pin_drv | output | CORE_W | Values presented at the output side |

## Verification
The properties assume that tck runs freely, that tms and tdi settle well clear of the rising edge, and that trst_n is released between clock edges. The five-high-TMS property further assumes that tms is a clean level at every rising edge. The stimulus changes tms, tdi, core_val, sys_val and trst_n only just after a falling edge, so every rising edge samples quiet inputs. A behavioural model of the controller, written as a transition table with bit queues for the shift paths, predicts every output. The bench compares against that model after each rising edge and after each falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PADR, ST_EX2DR,
    ST_UPDR, ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAIR, ST_EX2IR, ST_UPIR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b1110;
  localparam logic [IR_W-1:0] OP_INTEST  = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] { SEL_BYPASS, SEL_IDCODE, SEL_SCAN } dr_sel_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm import tap_pkg::*; (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_TLR:   state_nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   state_nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: state_nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: state_nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  state_nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: state_nxt = tms ? ST_UPDR  : ST_PADR;
      ST_PADR:  state_nxt = tms ? ST_EX2DR : ST_PADR;
      ST_EX2DR: state_nxt = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  state_nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: state_nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: state_nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  state_nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: state_nxt = tms ? ST_UPIR  : ST_PAIR;
      ST_PAIR:  state_nxt = tms ? ST_EX2IR : ST_PAIR;
      ST_EX2IR: state_nxt = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  state_nxt = tms ? ST_SELDR : ST_RTI;
      default:  state_nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir import tap_pkg::*; (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_lsb,
  output dr_sel_e         sel
);
  logic [IR_W-1:0] sh_q, sh_nxt, ir_nxt;
  logic            sh_en, ir_en;

  assign sh_en  = (state == ST_CAPIR) || (state == ST_SHIR);
  assign sh_nxt = (state == ST_CAPIR) ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
  assign ir_en  = (state == ST_TLR) || (state == ST_UPIR);
  assign ir_nxt = (state == ST_TLR) ? OP_IDCODE : sh_q;
  assign ir_lsb = sh_q[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir   <= OP_IDCODE;
    end else begin
      if (sh_en) sh_q <= sh_nxt;
      if (ir_en) ir   <= ir_nxt;
    end
  end

  always_comb begin
    unique case (ir)
      OP_IDCODE: sel = SEL_IDCODE;
      OP_INTEST: sel = SEL_SCAN;
      default:   sel = SEL_BYPASS;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr import tap_pkg::*; #(
  parameter int          CORE_W   = 6,
  parameter int          SYS_W    = 5,
  parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
  input  logic                      tck,
  input  logic                      rst_n,
  input  logic                      tdi,
  input  tap_state_e                state,
  input  dr_sel_e                   sel,
  input  logic [CORE_W-1:0]         core_val,
  input  logic [SYS_W-1:0]          sys_val,
  output logic                      dr_lsb,
  output logic [CORE_W+SYS_W-1:0]   upd_q
);
  localparam int SCAN_W = CORE_W + SYS_W;
  localparam int ID_W   = 32;

  logic cap, shf, act;
  assign cap = (state == ST_CAPDR);
  assign shf = (state == ST_SHDR);
  assign act = cap || shf;

  logic              byp_q, byp_nxt, byp_en;
  logic [ID_W-1:0]   id_q, id_nxt;
  logic              id_en;
  logic [SCAN_W-1:0] scan_q, scan_nxt, cap_vec;
  logic              scan_en, upd_en;

  assign byp_en  = act && (sel == SEL_BYPASS);
  assign byp_nxt = cap ? 1'b0 : tdi;
  assign id_en   = act && (sel == SEL_IDCODE);
  assign id_nxt  = cap ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
  assign scan_en = act && (sel == SEL_SCAN);
  assign upd_en  = (state == ST_UPDR) && (sel == SEL_SCAN);
  assign cap_vec = {core_val, sys_val};

  for (genvar i = 0; i < SCAN_W; i++) begin : g_cell
    if (i == SCAN_W - 1) begin : g_head
      assign scan_nxt[i] = cap ? cap_vec[i] : tdi;
    end else begin : g_body
      assign scan_nxt[i] = cap ? cap_vec[i] : scan_q[i+1];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q  <= 1'b0;
      id_q   <= ID_VALUE;
      scan_q <= '0;
      upd_q  <= '0;
    end else begin
      if (byp_en)  byp_q  <= byp_nxt;
      if (id_en)   id_q   <= id_nxt;
      if (scan_en) scan_q <= scan_nxt;
      if (upd_en)  upd_q  <= scan_q;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IDCODE: dr_lsb = id_q[0];
      SEL_SCAN:   dr_lsb = scan_q[0];
      default:    dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/tap_port.sv
module tap_port import tap_pkg::*; #(
  parameter int          CORE_W     = 6,
  parameter int          SYS_W      = 5,
  parameter logic [3:0]  ID_VERSION = 4'h2,
  parameter logic [15:0] ID_PART    = 16'h5C31,
  parameter logic [10:0] ID_MFR     = 11'h0A7
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [CORE_W-1:0] core_val,
  input  logic [SYS_W-1:0]  sys_val,
  output logic              tdo,
  output logic              tdo_en,
  output logic              test_mode,
  output logic [SYS_W-1:0]  core_drv,
  output logic [CORE_W-1:0] pin_drv
);
  localparam int          SCAN_W   = CORE_W + SYS_W;
  localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_lsb, dr_lsb;
  dr_sel_e         sel;
  logic [SCAN_W-1:0] upd_q;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir(ir), .ir_lsb(ir_lsb), .sel(sel)
  );

  tap_dr #(.CORE_W(CORE_W), .SYS_W(SYS_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .sel(sel),
    .core_val(core_val), .sys_val(sys_val), .dr_lsb(dr_lsb), .upd_q(upd_q)
  );

  logic tdo_nxt, en_nxt;
  always_comb begin
    en_nxt  = (state == ST_SHIR) || (state == ST_SHDR);
    tdo_nxt = 1'b0;
    if (state == ST_SHIR)      tdo_nxt = ir_lsb;
    else if (state == ST_SHDR) tdo_nxt = dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= en_nxt;
    end
  end

  assign test_mode = (sel == SEL_SCAN);
  assign core_drv  = test_mode ? upd_q[SYS_W-1:0]      : sys_val;
  assign pin_drv   = test_mode ? upd_q[SCAN_W-1:SYS_W] : core_val;
endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk import tap_pkg::*; #(
  parameter int CORE_W = 6,
  parameter int SYS_W  = 5
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tms,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir,
  input logic              tdo,
  input logic              tdo_en,
  input logic              test_mode,
  input logic [CORE_W-1:0] core_val,
  input logic [SYS_W-1:0]  sys_val,
  input logic [SYS_W-1:0]  core_drv,
  input logic [CORE_W-1:0] pin_drv
);
  // R1
  five_high_tms_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == ST_TLR));

  // R2
  tlr_default_ir_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir == OP_IDCODE));

  // R9
  normal_pass_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !test_mode |-> (core_drv == sys_val && pin_drv == core_val));

  // R8
  test_entry_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(test_mode) |-> ($past(state) == ST_UPIR));

  // R10
  tdo_window_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (state == ST_SHIR || state == ST_SHDR));

  // R10
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> !tdo);
endmodule

bind tap_port tap_port_chk #(.CORE_W(CORE_W), .SYS_W(SYS_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .ir(ir),
  .tdo(tdo), .tdo_en(tdo_en), .test_mode(test_mode),
  .core_val(core_val), .sys_val(sys_val), .core_drv(core_drv), .pin_drv(pin_drv)
);

// File: tb/tap_port_test.sv
`timescale 1ns/1ps
module tap_port_test;
  localparam int CW = 6;
  localparam int SW = 5;
  localparam int NW = CW + SW;
  localparam logic [31:0] EXP_ID = {4'h2, 16'h5C31, 11'h0A7, 1'b1};

  localparam int TLR=0, RTI=1, SELDR=2, CAPDR=3, SHDR=4, EX1DR=5, PADR=6, EX2DR=7,
                 UPDR=8, SELIR=9, CAPIR=10, SHIR=11, EX1IR=12, PAIR=13, EX2IR=14, UPIR=15;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [CW-1:0] core_val = 6'h2D;
  logic [SW-1:0] sys_val  = 5'h13;
  logic tdo, tdo_en, test_mode;
  logic [SW-1:0] core_drv;
  logic [CW-1:0] pin_drv;

  tap_port uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .core_val(core_val), .sys_val(sys_val),
    .tdo(tdo), .tdo_en(tdo_en), .test_mode(test_mode),
    .core_drv(core_drv), .pin_drv(pin_drv)
  );

  always #4 tck = ~tck;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int         ms;
  logic [3:0] mir;
  bit         irq[$];
  bit         drq[$];
  logic [NW-1:0] mupd;
  logic       mtdo, men;
  logic       last_tdo;

  function automatic int next_state(input int s, input bit t);
    case (s)
      TLR:   return t ? TLR   : RTI;
      RTI:   return t ? SELDR : RTI;
      SELDR: return t ? SELIR : CAPDR;
      CAPDR: return t ? EX1DR : SHDR;
      SHDR:  return t ? EX1DR : SHDR;
      EX1DR: return t ? UPDR  : PADR;
      PADR:  return t ? EX2DR : PADR;
      EX2DR: return t ? UPDR  : SHDR;
      UPDR:  return t ? SELDR : RTI;
      SELIR: return t ? TLR   : CAPIR;
      CAPIR: return t ? EX1IR : SHIR;
      SHIR:  return t ? EX1IR : SHIR;
      EX1IR: return t ? UPIR  : PAIR;
      PAIR:  return t ? EX2IR : PAIR;
      EX2IR: return t ? UPIR  : SHIR;
      default: return t ? SELDR : RTI;
    endcase
  endfunction

  task automatic model_reset();
    ms = TLR; mir = 4'b1110; irq.delete(); drq.delete();
    mupd = '0; mtdo = 1'b0; men = 1'b0;
  endtask

  task automatic model_rise();
    logic [NW-1:0] cv;
    case (ms)
      TLR:   mir = 4'b1110;
      CAPIR: begin irq.delete(); irq.push_back(1); irq.push_back(0); irq.push_back(0); irq.push_back(0); end
      SHIR:  begin void'(irq.pop_front()); irq.push_back(tdi); end
      UPIR:  mir = {irq[3], irq[2], irq[1], irq[0]};
      CAPDR: begin
        drq.delete();
        if (mir == 4'b1110) for (int i = 0; i < 32; i++) drq.push_back(EXP_ID[i]);
        else if (mir == 4'b1100) begin
          cv = {core_val, sys_val};
          for (int i = 0; i < NW; i++) drq.push_back(cv[i]);
        end else drq.push_back(0);
      end
      SHDR:  begin void'(drq.pop_front()); drq.push_back(tdi); end
      UPDR:  if (mir == 4'b1100) for (int i = 0; i < NW; i++) mupd[i] = drq[i];
      default: ;
    endcase
    ms = next_state(ms, tms);
  endtask

  task automatic model_fall();
    men  = (ms == SHIR) || (ms == SHDR);
    mtdo = (ms == SHIR) ? irq[0] : (ms == SHDR) ? drq[0] : 1'b0;
  endtask

  task automatic cmp_parallel();
    logic tm;
    tm = (mir == 4'b1100);
    chk(test_mode == tm, "R8", "test_mode", 64'(test_mode), 64'(tm));
    chk(core_drv == (tm ? mupd[SW-1:0] : sys_val), "R9", "core_drv",
        64'(core_drv), 64'(tm ? mupd[SW-1:0] : sys_val));
    chk(pin_drv == (tm ? mupd[NW-1:SW] : core_val), "R9", "pin_drv",
        64'(pin_drv), 64'(tm ? mupd[NW-1:SW] : core_val));
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t; tdi = d;
    @(posedge tck);
    if (trst_n) model_rise();
    #1;
    // R10: serial outputs hold across the rising edge
    chk(tdo === mtdo, "R10", "tdo after rise", 64'(tdo), 64'(mtdo));
    chk(tdo_en === men, "R10", "tdo_en after rise", 64'(tdo_en), 64'(men));
    cmp_parallel();
    @(negedge tck);
    if (trst_n) model_fall();
    #1;
    chk(tdo === mtdo, "R10", "tdo after fall", 64'(tdo), 64'(mtdo));
    chk(tdo_en === men, "R10", "tdo_en after fall", 64'(tdo_en), 64'(men));
    last_tdo = tdo;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] seen);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      seen[i] = last_tdo;
      tick(i == 3, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, input int pause_at,
                         output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = last_tdo;
      if (i == pause_at && i != n - 1) begin
        tick(1, din[i]); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
      end else tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0]  irseen;
    logic [63:0] dout, din;
    model_reset();
    #3;
    chk(tdo_en === 1'b0, "R2", "tdo_en in reset", 64'(tdo_en), 0);
    chk(test_mode === 1'b0, "R2", "test_mode in reset", 64'(test_mode), 0);
    tick(1, 0); tick(1, 0);
    trst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);

    // R6: default instruction is IDCODE, identity shifts out with a pause
    scan_dr(64'h0, 32, 12, dout);
    chk(dout[31:0] == EXP_ID, "R6", "identity read", dout, 64'(EXP_ID));
    chk(dout[0] == 1'b1, "R6", "identity lsb", 64'(dout[0]), 1);

    // R6: long shift passes TDI through 32 stages
    din = 64'hA5C3_0F96_1234_ABCD;
    scan_dr(din, 64, -1, dout);
    chk(dout[63:32] == din[31:0], "R6", "id passthrough", 64'(dout[63:32]), 64'(din[31:0]));
    // R7: update under IDCODE leaves the cells in normal mode
    chk(core_drv == sys_val && pin_drv == core_val && !test_mode, "R7", "idcode update",
        {core_drv, pin_drv}, {sys_val, core_val});

    // R3: capture pattern, R5: bypass
    load_ir(4'b1111, irseen);
    chk(irseen == 4'b0001, "R3", "ir capture", 64'(irseen), 64'h1);
    din = 64'h00000000_000000B6;
    scan_dr(din, 8, -1, dout);
    chk(dout[0] == 1'b0, "R5", "bypass capture", 64'(dout[0]), 0);
    chk(dout[7:1] == din[6:0], "R5", "bypass delay", 64'(dout[7:1]), 64'(din[6:0]));

    // R4: unlisted opcode acts as bypass
    load_ir(4'b1010, irseen);
    din = 64'h0000_0000_0000_0059;
    scan_dr(din, 8, 3, dout);
    chk(dout[7:0] == {din[6:0], 1'b0}, "R4", "unlisted opcode bypass",
        64'(dout[7:0]), 64'({din[6:0], 1'b0}));
    chk(!test_mode, "R4", "unlisted not test", 64'(test_mode), 0);

    // R8: scan chain
    load_ir(4'b1100, irseen);
    chk(test_mode === 1'b1, "R8", "test_mode on", 64'(test_mode), 1);
    core_val = 6'h1B; sys_val = 5'h0A;
    din = 64'h0000_0000_0000_05E7;
    scan_dr(din, NW, -1, dout);
    chk(dout[NW-1:0] == {6'h1B, 5'h0A}, "R8", "scan capture", 64'(dout[NW-1:0]), 64'({6'h1B, 5'h0A}));
    // R9: parallel values driven in test mode
    chk(core_drv == din[SW-1:0], "R9", "core_drv test", 64'(core_drv), 64'(din[SW-1:0]));
    chk(pin_drv == din[NW-1:SW], "R9", "pin_drv test", 64'(pin_drv), 64'(din[NW-1:SW]));
    sys_val = 5'h1F; core_val = 6'h00;
    #1;
    chk(core_drv == din[SW-1:0], "R9", "core_drv ignores sys_val", 64'(core_drv), 64'(din[SW-1:0]));

    // R1: asynchronous reset mid-run
    trst_n = 1'b0;
    model_reset();
    #1;
    chk(!test_mode && core_drv == sys_val, "R1", "trst clears test mode", 64'(test_mode), 0);
    chk(!tdo_en, "R1", "trst disables tdo", 64'(tdo_en), 0);
    tick(1, 0);
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1, 0);
    tick(0, 0);

    // R1: five TMS-high edges from Shift-DR
    load_ir(4'b1100, irseen);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 1);
    tick(1, 0);
    chk(!test_mode, "R1", "five ones reset", 64'(test_mode), 0);
    tick(0, 0);
    scan_dr(64'h0, 32, -1, dout);
    chk(dout[31:0] == EXP_ID, "R2", "idcode after tms reset", dout, 64'(EXP_ID));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule